// File: doc/BRIEF.md
# Composite-Field GF(4096) Multiplier with Power-Sequence Stepper

This block multiplies 12-bit Galois-field elements. It builds the 12-bit field as a quadratic extension over a 6-bit base field. Each element is split into an upper and a lower 6-bit half, and the product is assembled from a few 6-bit sub-products. The operand path takes two elements with a valid strobe and returns the product one clock later.

The operand path has a second mode, the stepping function. This function maps an element to its product with the fixed generator 0xE01 and maps zero to one. Alongside the operand path, a power-sequence stepper starts from one on a start pulse. On each enabled cycle it multiplies its value by the generator, which yields the successive powers needed to fill log and antilog tables. It flags the step on which the sequence comes back to one.

Top module: `gf4096_mult`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `seq_active` and `seq_wrap` are 0 and `seq_value` is 0x000.
- R2: When `in_valid` is 1 and `in_mode` is 0, the next cycle shows `out_valid` = 1 and `out_prod` = `in_a`·`in_b`. `out_valid` is 0 in every cycle that does not follow an accepted input.
- R3: Bits 11:6 and 5:0 of an element are its high and low base-field halves. Base-field products are reduced by x^6+x+1. The product's high half is (ah⊕al)(bh⊕bl) ⊕ al·bl, and its low half is (ah·bh)·0x21 ⊕ al·bl. Examples: 0x040·0x040 = 0x061 and 0x020·0x020 = 0x030.
- R4: Multiplying by 0x001 returns the other operand. Multiplying by 0x000 returns 0x000. Swapping the operands does not change the product.
- R5: When `in_mode` is 1, the product is `in_a`·0xE01. An `in_a` of 0x000 gives 0x001. `in_b` has no effect in this mode.
- R6: A `seq_start` pulse sets `seq_value` to 0x001, sets `seq_active` and clears `seq_wrap` on the next cycle. This takes priority over a step requested in the same cycle.
- R7: While `seq_active` is 1 and `seq_run` is 1, `seq_value` becomes `seq_value`·0xE01 each cycle. With `seq_run` at 0, the value and the wrap flag hold.
- R8: `seq_wrap` becomes 1 on the step whose result is 0x001 and becomes 0 on the next step or start. Stepping from 0x001, the first wrap comes after as many steps as the multiplicative order of 0xE01, which is 4095 for a primitive generator.
- R9: `seq_run` has no effect while `seq_active` is 0: `seq_value` stays 0x000.
- R10: The operand path and the stepper act in the same cycle without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair valid |
| in_mode | input | 1 | 0 = multiply a·b, 1 = stepping function of a |
| in_a | input | 12 | First operand |
| in_b | input | 12 | Second operand (multiply mode only) |
| out_valid | output | 1 | Product valid, one cycle after `in_valid` |
| out_prod | output | 12 | Registered product |
| seq_start | input | 1 | Restart the power sequence at one |
| seq_run | input | 1 | Advance the sequence this cycle |
| seq_value | output | 12 | Current power of the generator |
| seq_active | output | 1 | Sequence has been started |
| seq_wrap | output | 1 | Last step returned the sequence to one |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an operand multiply and a sequence step. The second pair is a start pulse and a step request, including a start in the very cycle the sequence has just wrapped. The bench drives operand pairs on every cycle of a running sequence and compares both outputs against its own field model each cycle. It raises `seq_start` together with `seq_run` both mid-sequence and at the wrap point, and expects 0x001 with the wrap flag low.

// File: rtl/gf12_pkg.sv
// Shared field constants and types for the 12-bit composite-field multiplier.
// Assumes the 12-bit field is a degree-2 extension over a 6-bit base field.
package gf12_pkg;
    localparam int HALF_W = 6;
    localparam int ELEM_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [ELEM_W-1:0] elem_t;

    // Low-order terms of the base reduction polynomial x^6 + x + 1
    localparam half_t BASE_POLY_LOW = 6'h03;
    // Constant term of the quadratic extension polynomial
    localparam half_t EXT_CONST     = 6'h21;
    // Generator used by the stepping function and the power sequence
    localparam elem_t STEP_GEN      = 12'hE01;
    localparam elem_t ELEM_ONE      = 12'h001;

    typedef enum logic {
        OP_MUL  = 1'b0,
        OP_STEP = 1'b1
    } op_mode_e;
endpackage

// File: rtl/gf64_mul.sv
// Base-field multiplier: shift-and-add over W unrolled stages.
// Assumes the reduction polynomial is x^W + POLY_LOW, with POLY_LOW given by its low W bits.
module gf64_mul #(
    parameter int            W        = gf12_pkg::HALF_W,
    parameter logic [W-1:0]  POLY_LOW = gf12_pkg::BASE_POLY_LOW
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] prod
);
    logic [W-1:0] acc   [0:W];
    logic [W-1:0] shift [0:W-1];

    // Seed the accumulator and the shifted multiplicand
    assign acc[0]   = '0;
    assign shift[0] = op_y;

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            // Add the shifted multiplicand when bit i of op_x is set
            assign acc[i+1] = acc[i] ^ ({W{op_x[i]}} & shift[i]);
            if (i < W - 1) begin : g_shift
                // Multiply by x and fold the overflow bit back in
                assign shift[i+1] = {shift[i][W-2:0], 1'b0} ^ ({W{shift[i][W-1]}} & POLY_LOW);
            end
        end
    endgenerate

    assign prod = acc[W];
endmodule

// File: rtl/gf4096_core.sv
// Combinational 12-bit field multiplier built from four base-field multipliers.
// Assumes the extension polynomial is y^2 + y + EXT_C over the base field.
module gf4096_core #(
    parameter int                HALF_W   = gf12_pkg::HALF_W,
    parameter logic [HALF_W-1:0] POLY_LOW = gf12_pkg::BASE_POLY_LOW,
    parameter logic [HALF_W-1:0] EXT_C    = gf12_pkg::EXT_CONST,
    localparam int               ELEM_W   = 2 * HALF_W
) (
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    output logic [ELEM_W-1:0] prod
);
    logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
    logic [HALF_W-1:0] sum_a, sum_b;
    logic [HALF_W-1:0] p_cross, p_low, p_high, p_ext;

    // Split the operands into their base-field halves
    assign a_hi  = op_a[ELEM_W-1:HALF_W];
    assign a_lo  = op_a[HALF_W-1:0];
    assign b_hi  = op_b[ELEM_W-1:HALF_W];
    assign b_lo  = op_b[HALF_W-1:0];
    assign sum_a = a_hi ^ a_lo;
    assign sum_b = b_hi ^ b_lo;

    gf64_mul #(.W(HALF_W), .POLY_LOW(POLY_LOW)) u_cross (
        .op_x(sum_a), .op_y(sum_b), .prod(p_cross)
    );
    gf64_mul #(.W(HALF_W), .POLY_LOW(POLY_LOW)) u_low (
        .op_x(a_lo), .op_y(b_lo), .prod(p_low)
    );
    gf64_mul #(.W(HALF_W), .POLY_LOW(POLY_LOW)) u_high (
        .op_x(a_hi), .op_y(b_hi), .prod(p_high)
    );
    gf64_mul #(.W(HALF_W), .POLY_LOW(POLY_LOW)) u_ext (
        .op_x(p_high), .op_y(EXT_C), .prod(p_ext)
    );

    // Recombine the halves of the product
    assign prod = {p_cross ^ p_low, p_ext ^ p_low};
endmodule

// File: rtl/gf_operand_stage.sv
// Operand path: selects plain multiply or the stepping function, registers the result.
// Assumes one result per cycle; the stepping function maps zero to one.
module gf_operand_stage #(
    parameter int                  HALF_W = gf12_pkg::HALF_W,
    localparam int                 ELEM_W = 2 * HALF_W,
    parameter logic [ELEM_W-1:0]   GEN    = gf12_pkg::STEP_GEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [ELEM_W-1:0] in_a,
    input  logic [ELEM_W-1:0] in_b,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_prod
);
    import gf12_pkg::*;

    localparam logic [ELEM_W-1:0] ONE = ELEM_W'(1);

    op_mode_e          mode;
    logic [ELEM_W-1:0] b_sel;
    logic [ELEM_W-1:0] core_prod;
    logic [ELEM_W-1:0] result;

    assign mode = op_mode_e'(in_mode);

    // Pick the second operand according to the mode
    always_comb begin
        b_sel = (mode == OP_STEP) ? GEN : in_b;
    end

    gf4096_core #(.HALF_W(HALF_W)) u_core (
        .op_a(in_a), .op_b(b_sel), .prod(core_prod)
    );

    // Apply the zero-to-one rule of the stepping function
    always_comb begin
        result = core_prod;
        if (mode == OP_STEP && in_a == '0) begin
            result = ONE;
        end
    end

    // Register the product and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_prod <= result;
            end
        end
    end
endmodule

// File: rtl/gf_seq_stepper.sv
// Power-sequence stepper: restarts at one, multiplies by GEN on each enabled cycle,
// and flags the step that returns to one. Assumes start takes priority over a step.
module gf_seq_stepper #(
    parameter int                  HALF_W = gf12_pkg::HALF_W,
    localparam int                 ELEM_W = 2 * HALF_W,
    parameter logic [ELEM_W-1:0]   GEN    = gf12_pkg::STEP_GEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    output logic [ELEM_W-1:0] value,
    output logic              active,
    output logic              wrap
);
    localparam logic [ELEM_W-1:0] ONE = ELEM_W'(1);

    logic [ELEM_W-1:0] core_prod;
    logic [ELEM_W-1:0] next_val;

    gf4096_core #(.HALF_W(HALF_W)) u_core (
        .op_a(value), .op_b(GEN), .prod(core_prod)
    );

    // Next power, with the zero-to-one rule of the stepping function
    always_comb begin
        next_val = (value == '0) ? ONE : core_prod;
    end

    // Sequence state: restart, advance or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value  <= '0;
            active <= 1'b0;
            wrap   <= 1'b0;
        end else if (start) begin
            value  <= ONE;
            active <= 1'b1;
            wrap   <= 1'b0;
        end else if (active && run) begin
            value  <= next_val;
            wrap   <= (next_val == ONE);
        end
    end
endmodule

// File: rtl/gf4096_mult.sv
// Top: 12-bit composite-field multiplier with a registered operand path
// and an independent power-sequence stepper. Assumes a single clock domain.
module gf4096_mult #(
    parameter int HALF_W = gf12_pkg::HALF_W,
    parameter logic [2*HALF_W-1:0] GEN = gf12_pkg::STEP_GEN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_mode,
    input  logic [2*HALF_W-1:0]   in_a,
    input  logic [2*HALF_W-1:0]   in_b,
    output logic                  out_valid,
    output logic [2*HALF_W-1:0]   out_prod,
    input  logic                  seq_start,
    input  logic                  seq_run,
    output logic [2*HALF_W-1:0]   seq_value,
    output logic                  seq_active,
    output logic                  seq_wrap
);
    gf_operand_stage #(.HALF_W(HALF_W), .GEN(GEN)) u_operand (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    gf_seq_stepper #(.HALF_W(HALF_W), .GEN(GEN)) u_stepper (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start), .run(seq_run),
        .value(seq_value), .active(seq_active), .wrap(seq_wrap)
    );
endmodule

// File: rtl/gf4096_mult_chk.sv
// Checker for gf4096_mult: temporal properties of both paths, bound to the top.
module gf4096_mult_chk #(
    parameter int ELEM_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_mode,
    input logic [ELEM_W-1:0] in_a,
    input logic [ELEM_W-1:0] in_b,
    input logic              out_valid,
    input logic [ELEM_W-1:0] out_prod,
    input logic              seq_start,
    input logic              seq_run,
    input logic [ELEM_W-1:0] seq_value,
    input logic              seq_active,
    input logic              seq_wrap
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4
    mul_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_a == ELEM_W'(1)) |=> out_prod == $past(in_b));
    // R4
    mul_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && (in_a == '0 || in_b == '0)) |=> out_prod == '0);
    // R5
    step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && in_a == '0) |=> out_prod == ELEM_W'(1));
    // R6
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (seq_value == ELEM_W'(1) && seq_active && !seq_wrap));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_start && !seq_run) |=> ($stable(seq_value) && $stable(seq_wrap)));
    // R7
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_start && seq_run && seq_active) |=> seq_value != $past(seq_value));
    // R8
    wrap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_wrap |-> seq_value == ELEM_W'(1));
    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_active && !seq_start) |=> (seq_value == '0 && !seq_active));
endmodule

bind gf4096_mult gf4096_mult_chk #(.ELEM_W(2*HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod),
    .seq_start(seq_start), .seq_run(seq_run),
    .seq_value(seq_value), .seq_active(seq_active), .seq_wrap(seq_wrap)
);

// File: tb/gf4096_mult_bench.sv
`timescale 1ns/1ps
module gf4096_mult_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [11:0] in_a = '0;
    logic [11:0] in_b = '0;
    logic        out_valid;
    logic [11:0] out_prod;
    logic        seq_start = 1'b0;
    logic        seq_run = 1'b0;
    logic [11:0] seq_value;
    logic        seq_active;
    logic        seq_wrap;

    int checks = 0;
    int errors = 0;
    int order  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gf4096_mult u_gf4096_mult (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod),
        .seq_start(seq_start), .seq_run(seq_run),
        .seq_value(seq_value), .seq_active(seq_active), .seq_wrap(seq_wrap)
    );

    // Model: carry-less product, then reduce by x^6 + x + 1 from the top bit down
    function automatic logic [5:0] m64(input logic [5:0] x, input logic [5:0] y);
        logic [10:0] t = '0;
        for (int i = 0; i < 6; i++) if (x[i]) t ^= 11'(y) << i;
        for (int k = 10; k >= 6; k--) if (t[k]) t ^= 11'h043 << (k - 6);
        return t[5:0];
    endfunction

    function automatic logic [11:0] m12(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] hi, lo;
        lo = m64(a[5:0], b[5:0]);
        hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo;
        return {hi, m64(m64(a[11:6], b[11:6]), 6'h21) ^ lo};
    endfunction

    function automatic logic [11:0] mstep(input logic [11:0] a);
        return (a == '0) ? 12'h001 : m12(a, 12'hE01);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One operand pair through the registered path
    task automatic mul_once(input logic mode, input logic [11:0] a, input logic [11:0] b,
                            input logic [11:0] exp, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, req, 32'(out_valid), 32'd1);
        chk(out_prod === exp, req, 32'(out_prod), 32'(exp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(seq_value === 12'h000, "R1 seq_value", 32'(seq_value), 32'd0);
        chk(seq_active === 1'b0, "R1 seq_active", 32'(seq_active), 32'd0);
        chk(seq_wrap === 1'b0, "R1 seq_wrap", 32'(seq_wrap), 32'd0);
    endtask

    task automatic t_mul_patterns();
        logic [11:0] av [8] = '{12'h001, 12'h040, 12'hFFF, 12'h03F, 12'hA5C, 12'h800, 12'h123, 12'hE01};
        logic [11:0] bv [8] = '{12'h7B3, 12'h040, 12'hFFF, 12'hFC0, 12'h3D2, 12'h001, 12'h456, 12'hE01};
        mul_once(1'b0, 12'h040, 12'h040, 12'h061, "R3 0x040 squared");
        mul_once(1'b0, 12'h020, 12'h020, 12'h030, "R3 0x020 squared");
        for (int i = 0; i < 8; i++) begin
            mul_once(1'b0, av[i], bv[i], m12(av[i], bv[i]), "R2 product");
        end
        @(negedge clk);
        chk(out_valid === 1'b0, "R2 valid drops", 32'(out_valid), 32'd0);
    endtask

    task automatic t_identity_zero();
        for (int i = 0; i < 8; i++) begin
            logic [11:0] v = 12'(i * 517 + 3);
            mul_once(1'b0, 12'h001, v, v, "R4 identity");
            mul_once(1'b0, v, 12'h000, 12'h000, "R4 zero");
            mul_once(1'b0, v, 12'hB7A, m12(12'hB7A, v), "R4 commutative");
        end
    endtask

    task automatic t_step_mode();
        mul_once(1'b1, 12'h000, 12'h5A5, 12'h001, "R5 zero to one");
        mul_once(1'b1, 12'h001, 12'h0F0, 12'hE01, "R5 one to generator");
        mul_once(1'b1, 12'h3C7, 12'h000, mstep(12'h3C7), "R5 step b=0");
        mul_once(1'b1, 12'h3C7, 12'hFFF, mstep(12'h3C7), "R5 b ignored");
    endtask

    task automatic t_idle();
        @(negedge clk);
        seq_run = 1'b1;
        repeat (3) @(negedge clk);
        seq_run = 1'b0;
        chk(seq_value === 12'h000, "R9 idle value", 32'(seq_value), 32'd0);
        chk(seq_active === 1'b0, "R9 idle active", 32'(seq_active), 32'd0);
    endtask

    // Full period with operand traffic in every cycle, then start at the wrap point
    task automatic t_full_sequence();
        logic [11:0] model = 12'h001;
        bit          wrapped = 1'b0;
        @(negedge clk);
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        chk(seq_value === 12'h001 && seq_active && !seq_wrap, "R6 start", 32'(seq_value), 32'h1);
        seq_run = 1'b1;
        for (int n = 1; n <= 4096 && !wrapped; n++) begin
            logic [11:0] oa = 12'(n * 37);
            logic [11:0] ob = 12'(n * 91 + 5);
            in_valid = 1'b1; in_mode = 1'b0; in_a = oa; in_b = ob;
            @(negedge clk);
            model = m12(model, 12'hE01);
            chk(seq_value === model, "R7 step value", 32'(seq_value), 32'(model));
            chk(seq_wrap === (model == 12'h001), "R8 wrap flag", 32'(seq_wrap), 32'(model == 12'h001));
            chk(out_valid && out_prod === m12(oa, ob), "R10 concurrent product", 32'(out_prod), 32'(m12(oa, ob)));
            if (model == 12'h001) begin
                wrapped = 1'b1;
                order = n;
            end
        end
        in_valid = 1'b0;
        chk(wrapped, "R8 sequence returned", 32'(order), 32'd4095);
        $display("Generator order: %0d", order);
        seq_run = 1'b0;
        @(negedge clk);
        chk(seq_wrap === 1'b1 && seq_value === 12'h001, "R7 hold wrap", 32'(seq_wrap), 32'd1);
        seq_start = 1'b1; seq_run = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        chk(seq_value === 12'h001 && !seq_wrap, "R6 start at wrap", 32'(seq_wrap), 32'd0);
        @(negedge clk);
        seq_run = 1'b0;
        chk(seq_value === 12'hE01 && !seq_wrap, "R8 clear on step", 32'(seq_value), 32'hE01);
    endtask

    task automatic t_hold_and_override();
        logic [11:0] held;
        seq_run = 1'b1;
        repeat (5) @(negedge clk);
        seq_run = 1'b0;
        held = seq_value;
        repeat (3) @(negedge clk);
        chk(seq_value === held, "R7 hold", 32'(seq_value), 32'(held));
        seq_start = 1'b1; seq_run = 1'b1;
        @(negedge clk);
        seq_start = 1'b0; seq_run = 1'b0;
        chk(seq_value === 12'h001, "R6 start over step", 32'(seq_value), 32'h1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mul_patterns();
        t_identity_zero();
        t_step_mode();
        t_idle();
        t_full_sequence();
        t_hold_and_override();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule